// File: doc/BRIEF.md
# Sector-Erase Data Flash Byte-Write Controller

This block fronts a small non-volatile scratchpad of 640 bytes. The storage can only be erased four bytes (one sector) at a time, and programming can only clear bits. Software reaches the storage through six byte-wide registers: two for the address, one for data, one for commands, one read-only status byte and one spare byte for general use. It never addresses the cells directly.

Three commands are available: fetch a byte into the data register, write a byte, and erase a sector. The byte write makes the sector erase invisible to software. The controller copies the four bytes of the target sector into a local buffer and puts the new byte into the buffer. It then erases the sector and programs all four bytes back. Erase and program phases each last a set number of clocks. A busy flag stays high for the whole command, and any command written while busy is dropped.

Top module: `dflash_ctrl`

## Requirements
- R1: After reset, busy and error read 0, every register reads 00h, and every storage byte reads FFh.
- R2: Register offsets are: 0 address bits [7:0], 1 address bits [9:8] in bits [1:0] with bits [7:2] reading 0, 2 data, 3 command (write-only, reads 00h), 4 status (bit 0 busy, bit 1 error), 5 spare read/write byte. Offsets 6 and 7 read 00h.
- R3: Command 01h keeps busy high for exactly one cycle. It then loads the data register with the byte at the address.
- R4: Command 02h replaces the addressed byte with the data register value, even where that needs bits set from 0 to 1. The other three bytes of its sector and all other sectors keep their contents.
- R5: Command 04h sets all four bytes of sector address[9:2] to FFh and keeps busy high for ERASE_CYC cycles.
- R6: Command 02h keeps busy high for 4 + ERASE_CYC + 4*PROG_CYC cycles.
- R7: A command with an address of 640 or above sets error, does not raise busy and leaves the storage unchanged.
- R8: A command code other than 01h, 02h or 04h sets error, does not raise busy and leaves the storage unchanged.
- R9: A command written while busy is ignored: error is unchanged and the storage is unaffected.
- R10: An accepted command clears error.
- R11: A storage byte is only programmed when it is FFh, so the program step never needs to raise a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | Last command was rejected |

## Verification
The assertions check these rules on every cycle:
- a rejected address or code raises error without raising busy;
- an accepted command clears error and raises busy;
- a command written while busy leaves error and the latched target alone;
- the read state lasts one cycle;
- an erased sector reads FFh afterwards;
- every byte is FFh at the moment it is programmed.

Only the bench scenarios can show that the merged byte lands at the right offset and that its neighbours survive the erase. The same applies to exact busy durations and to an ignored command leaving another sector's data in place.

// File: rtl/dflash_pkg.sv
package dflash_pkg;
  localparam logic [7:0] OP_FETCH = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WIPE  = 8'h04;

  localparam int          RSEL_W  = 3;
  localparam logic [2:0]  OFS_ALO = 3'd0;
  localparam logic [2:0]  OFS_AHI = 3'd1;
  localparam logic [2:0]  OFS_DAT = 3'd2;
  localparam logic [2:0]  OFS_CMD = 3'd3;
  localparam logic [2:0]  OFS_STS = 3'd4;
  localparam logic [2:0]  OFS_SPR = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_COPY,
    ST_WIPE,
    ST_BURN
  } seq_state_e;
endpackage

// File: rtl/dflash_array.sv
module dflash_array #(
  parameter int NUM_BYTES = 640,
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     erase_en,
  input  logic [ADDR_W-SECT_W-1:0] erase_sect,
  input  logic                     prog_en,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [7:0]               prog_data
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_BYTES);

  logic [7:0] cells [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(g);
    logic       hit_erase, hit_prog, cell_en;
    logic [7:0] cell_d, cell_q;

    always_comb begin
      hit_erase = erase_en && (erase_sect == CA[ADDR_W-1:SECT_W]);
      hit_prog  = prog_en && (prog_addr == CA);
      cell_en   = hit_erase || hit_prog;
      cell_d    = hit_erase ? 8'hFF : (cell_q & prog_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (cell_en) cell_q <= cell_d;
    end

    assign cells[g] = cell_q;
  end

  assign rd_data = (rd_addr < LIMIT) ? cells[rd_addr] : 8'hFF;

  // R11
  prog_on_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (cells[prog_addr] == 8'hFF));

  // R5
  erase_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (cells[{$past(erase_sect), SECT_W'(0)}] == 8'hFF));
endmodule

// File: rtl/dflash_regs.sv
module dflash_regs
  import dflash_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  input  logic              err,
  input  logic              load_en,
  input  logic [7:0]        load_data,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              cmd_wr,
  output logic [7:0]        cmd_code
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0]      alo_q, alo_d, dat_q, dat_d, spr_q, spr_d;
  logic [HI_W-1:0] ahi_q, ahi_d;

  always_comb begin
    alo_d = alo_q;
    ahi_d = ahi_q;
    dat_d = dat_q;
    spr_d = spr_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_ALO: alo_d = reg_wdata;
        OFS_AHI: ahi_d = reg_wdata[HI_W-1:0];
        OFS_DAT: dat_d = reg_wdata;
        OFS_SPR: spr_d = reg_wdata;
        default: ;
      endcase
    end
    if (load_en) dat_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
      dat_q <= '0;
      spr_q <= '0;
    end else begin
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      dat_q <= dat_d;
      spr_q <= spr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ALO: reg_rdata = alo_q;
      OFS_AHI: reg_rdata = 8'(ahi_q);
      OFS_DAT: reg_rdata = dat_q;
      OFS_STS: reg_rdata = {6'b0, err, busy};
      OFS_SPR: reg_rdata = spr_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign addr_o   = {ahi_q, alo_q};
  assign data_o   = dat_q;
  assign cmd_wr   = reg_we && (reg_addr == OFS_CMD);
  assign cmd_code = reg_wdata;
endmodule

// File: rtl/dflash_seq.sv
module dflash_seq
  import dflash_pkg::*;
#(
  parameter int NUM_BYTES = 640,
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 2,
  parameter int ERASE_CYC = 16,
  parameter int PROG_CYC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_wr,
  input  logic [7:0]               cmd_code,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic [7:0]               data_in,
  output logic                     busy,
  output logic                     err,
  output logic [ADDR_W-1:0]        arr_rd_addr,
  input  logic [7:0]               arr_rd_data,
  output logic                     erase_en,
  output logic [ADDR_W-SECT_W-1:0] erase_sect,
  output logic                     prog_en,
  output logic [ADDR_W-1:0]        prog_addr,
  output logic [7:0]               prog_data,
  output logic                     load_en,
  output logic [7:0]               load_data
);
  localparam int SECT_BYTES = 1 << SECT_W;
  localparam int MAXC       = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W      = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0]  E_LAST   = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0]  P_LAST   = CNT_W'(PROG_CYC - 1);
  localparam logic [SECT_W-1:0] IDX_LAST = SECT_W'(SECT_BYTES - 1);
  localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(NUM_BYTES);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [7:0]        val_q, val_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;
  logic [SECT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        sbuf_q [SECT_BYTES];
  logic [7:0]        sbuf_d [SECT_BYTES];
  logic [ADDR_W-1:0] base;
  logic              code_ok, addr_ok, accept;

  assign base    = {tgt_q[ADDR_W-1:SECT_W], idx_q};
  assign code_ok = (cmd_code == OP_FETCH) || (cmd_code == OP_WRITE) || (cmd_code == OP_WIPE);
  assign addr_ok = addr_in < LIMIT;
  assign accept  = cmd_wr && (state_q == ST_IDLE) && code_ok && addr_ok;

  always_comb begin
    state_d     = state_q;
    tgt_d       = tgt_q;
    val_d       = val_q;
    wr_d        = wr_q;
    err_d       = err_q;
    idx_d       = idx_q;
    cnt_d       = cnt_q;
    sbuf_d      = sbuf_q;
    arr_rd_addr = base;
    erase_en    = 1'b0;
    prog_en     = 1'b0;
    load_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          if (accept) begin
            err_d = 1'b0;
            tgt_d = addr_in;
            val_d = data_in;
            idx_d = '0;
            cnt_d = '0;
            wr_d  = (cmd_code == OP_WRITE);
            if (cmd_code == OP_FETCH)      state_d = ST_FETCH;
            else if (cmd_code == OP_WRITE) state_d = ST_COPY;
            else                           state_d = ST_WIPE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        arr_rd_addr = tgt_q;
        load_en     = 1'b1;
        state_d     = ST_IDLE;
      end
      ST_COPY: begin
        sbuf_d[idx_q] = (idx_q == tgt_q[SECT_W-1:0]) ? val_q : arr_rd_data;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = ST_WIPE;
      end
      ST_WIPE: begin
        if (cnt_q == E_LAST) begin
          erase_en = 1'b1;
          cnt_d    = '0;
          idx_d    = '0;
          state_d  = wr_q ? ST_BURN : ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_BURN: begin
        if (cnt_q == P_LAST) begin
          prog_en = 1'b1;
          cnt_d   = '0;
          idx_d   = idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      val_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      sbuf_q  <= '{default: '0};
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      val_q   <= val_d;
      wr_q    <= wr_d;
      err_q   <= err_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      sbuf_q  <= sbuf_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign err        = err_q;
  assign erase_sect = tgt_q[ADDR_W-1:SECT_W];
  assign prog_addr  = base;
  assign prog_data  = sbuf_q[idx_q];
  assign load_data  = arr_rd_data;

  // R9
  busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(err) && $stable(tgt_q)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !addr_ok) |=> (err && !busy));

  // R8
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !code_ok) |=> (err && !busy));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && code_ok && addr_ok) |=> (!err && busy));

  // R3
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dflash_ctrl.sv
module dflash_ctrl #(
  parameter int NUM_BYTES = 640,
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 2,
  parameter int ERASE_CYC = 16,
  parameter int PROG_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy_o,
  output logic       err_o
);
  logic                     busy, err, load_en, cmd_wr;
  logic [7:0]               load_data, data_val, cmd_code, rd_data, prog_data;
  logic [ADDR_W-1:0]        addr_val, rd_addr, prog_addr;
  logic                     erase_en, prog_en;
  logic [ADDR_W-SECT_W-1:0] erase_sect;

  dflash_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .err(err),
    .load_en(load_en), .load_data(load_data), .addr_o(addr_val),
    .data_o(data_val), .cmd_wr(cmd_wr), .cmd_code(cmd_code)
  );

  dflash_seq #(
    .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .addr_in(addr_val), .data_in(data_val), .busy(busy), .err(err),
    .arr_rd_addr(rd_addr), .arr_rd_data(rd_data), .erase_en(erase_en),
    .erase_sect(erase_sect), .prog_en(prog_en), .prog_addr(prog_addr),
    .prog_data(prog_data), .load_en(load_en), .load_data(load_data)
  );

  dflash_array #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .erase_en(erase_en), .erase_sect(erase_sect), .prog_en(prog_en),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  assign busy_o = busy;
  assign err_o  = err;
endmodule

// File: tb/test_dflash_ctrl.sv
module test_dflash_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int E = 3;
  localparam int P = 2;
  localparam int NB = 640;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd4;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       busy_o, err_o;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;

  dflash_ctrl #(.ERASE_CYC(E), .PROG_CYC(P)) i_dflash_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_mem [NB];
  int         rem;
  logic       m_err;
  logic [7:0] m_alo, m_data, m_spare, p_op, p_data;
  logic [1:0] m_ahi;
  int         p_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      rem = 0; m_err = 1'b0; m_alo = 0; m_ahi = 0; m_data = 0; m_spare = 0;
      p_op = 0; p_data = 0; p_addr = 0;
    end else begin
      bit done;
      int a;
      done = 1'b0;
      a = {m_ahi, m_alo};
      if (rem > 0) begin
        rem--;
        done = (rem == 0);
      end else if (reg_we && reg_addr == 3'd3) begin
        if (a < NB && (reg_wdata == 8'h01 || reg_wdata == 8'h02 || reg_wdata == 8'h04)) begin
          m_err = 1'b0; p_op = reg_wdata; p_addr = a; p_data = m_data;
          rem = (reg_wdata == 8'h01) ? 1 : (reg_wdata == 8'h04) ? E : 4 + E + 4*P;
        end else m_err = 1'b1;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_alo = reg_wdata;
          3'd1: m_ahi = reg_wdata[1:0];
          3'd2: m_data = reg_wdata;
          3'd5: m_spare = reg_wdata;
          default: ;
        endcase
      end
      if (done) begin
        if (p_op == 8'h01) m_data = m_mem[p_addr];
        else if (p_op == 8'h04) for (int k = 0; k < 4; k++) m_mem[(p_addr & ~3) + k] = 8'hFF;
        else m_mem[p_addr] = p_data;
      end
    end
  end

  function automatic logic [7:0] m_rdata(input logic [2:0] o);
    case (o)
      3'd0: return m_alo;
      3'd1: return {6'b0, m_ahi};
      3'd2: return m_data;
      3'd4: return {6'b0, m_err, rem > 0};
      3'd5: return m_spare;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (chk_on) begin
      chk(busy_o == (rem > 0), "R6 busy per cycle", busy_o, rem > 0);
      chk(err_o == m_err, "R10 error per cycle", err_o, m_err);
      chk(reg_rdata == m_rdata(reg_addr), "R2 register read per cycle", reg_rdata, m_rdata(reg_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic set_addr(input int a);
    wr(3'd0, 8'(a));
    wr(3'd1, 8'(a >> 8));
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic peek(input logic [2:0] o, output logic [7:0] v);
    @(negedge clk);
    reg_addr = o;
    #2 v = reg_rdata;
    reg_addr = 3'd4;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] v, output int n);
    set_addr(a);
    wr(3'd3, 8'h01);
    wait_idle(n);
    peek(3'd2, v);
  endtask

  task automatic prog_byte(input int a, input logic [7:0] d, output int n);
    set_addr(a);
    wr(3'd2, d);
    wr(3'd3, 8'h02);
    wait_idle(n);
  endtask

  task automatic expect_byte(input int a, input logic [7:0] e, input string req);
    logic [7:0] v;
    int n;
    rd_byte(a, v, n);
    chk(v == e, req, v, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R1 reset state
    @(negedge clk);
    #2;
    chk(!busy_o && !err_o, "R1 status after reset", {err_o, busy_o}, 0);
    for (int o = 0; o < 8; o++) begin
      peek(3'(o), v);
      chk(v == 8'h00, "R1 register after reset", v, 0);
    end
    expect_byte(5, 8'hFF, "R1 erased storage at 5");
    expect_byte(639, 8'hFF, "R1 erased storage at 639");

    // R2 register map
    wr(3'd1, 8'hFF);
    peek(3'd1, v); chk(v == 8'h03, "R2 high address bits", v, 8'h03);
    wr(3'd5, 8'hC3);
    peek(3'd5, v); chk(v == 8'hC3, "R2 spare byte", v, 8'hC3);
    wr(3'd6, 8'h55);
    peek(3'd6, v); chk(v == 8'h00, "R2 offset 6 reads zero", v, 0);
    peek(3'd3, v); chk(v == 8'h00, "R2 command reads zero", v, 0);

    // R3 fetch length
    set_addr(10);
    wr(3'd3, 8'h01);
    wait_idle(n);
    chk(n == 1, "R3 fetch busy cycles", n, 1);

    // R4 / R6 byte write with merge
    prog_byte(258, 8'h5A, n);
    chk(n == 4 + E + 4*P, "R6 write busy cycles", n, 4 + E + 4*P);
    expect_byte(256, 8'hFF, "R4 neighbour 256");
    expect_byte(258, 8'h5A, "R4 target 258");
    expect_byte(259, 8'hFF, "R4 neighbour 259");
    prog_byte(257, 8'h3C, n);
    expect_byte(257, 8'h3C, "R4 target 257");
    expect_byte(258, 8'h5A, "R4 neighbour 258 kept");
    prog_byte(258, 8'hA5, n);
    expect_byte(258, 8'hA5, "R4 rewrite raises bits");
    expect_byte(257, 8'h3C, "R4 neighbour 257 kept");
    expect_byte(260, 8'hFF, "R4 next sector untouched");

    // R11 edge addresses
    prog_byte(0, 8'h00, n);
    expect_byte(0, 8'h00, "R11 first byte");
    prog_byte(639, 8'h81, n);
    expect_byte(639, 8'h81, "R11 last byte");

    // R5 sector erase
    set_addr(257);
    wr(3'd3, 8'h04);
    wait_idle(n);
    chk(n == E, "R5 erase busy cycles", n, E);
    expect_byte(257, 8'hFF, "R5 erased 257");
    expect_byte(258, 8'hFF, "R5 erased 258");
    expect_byte(639, 8'h81, "R5 other sector kept");

    // R7 out-of-range address
    set_addr(640);
    wr(3'd3, 8'h02);
    #2;
    chk(err_o && !busy_o, "R7 address 640 rejected", {err_o, busy_o}, 2);
    expect_byte(639, 8'h81, "R10 accepted read clears error and R7 storage kept");
    set_addr(1023);
    wr(3'd3, 8'h04);
    #2;
    chk(err_o && !busy_o, "R7 address 1023 rejected", {err_o, busy_o}, 2);

    // R8 unknown code
    set_addr(0);
    wr(3'd3, 8'h03);
    #2;
    chk(err_o && !busy_o, "R8 code 03h rejected", {err_o, busy_o}, 2);
    wr(3'd3, 8'h00);
    expect_byte(0, 8'h00, "R8 storage unchanged");

    // R9 command while busy
    prog_byte(32, 8'h77, n);
    set_addr(16);
    wr(3'd2, 8'h11);
    wr(3'd3, 8'h02);
    set_addr(32);
    wr(3'd3, 8'h04);
    #2;
    chk(busy_o && !err_o, "R9 status after ignored command", {err_o, busy_o}, 1);
    wait_idle(n);
    expect_byte(32, 8'h77, "R9 ignored erase left data");
    expect_byte(16, 8'h11, "R9 running write completed");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule